// File: doc/BRIEF.md
# Hamiltonian Cycle Search Engine

This block decides whether an undirected graph of `N` vertices has a closed tour that visits every vertex once. The search is spread over one small state machine per vertex. A single token of control moves between them to carry out a depth-first search with backtracking. A machine that holds the token either hands it to an idle neighbour or gives it back to the machine that woke it. No central stack exists: each machine keeps the index of its own parent and the position it has reached in its own neighbour list.

A client drives the adjacency bits and pulses `start`. The block captures the graph and wakes vertex 0, which is the root of the search. The search ends in one of two ways. It reports a hit when every vertex is busy and the machine holding the token has an edge back to vertex 0. It reports a miss when vertex 0 itself gives up. The verdict, the `done` flag and the elapsed cycle count then stay fixed until the next accepted start.

Top module: `hc_solver`

## Requirements
- R1: At any time at most one vertex machine holds the token. Only the holder changes state in a cycle, except for the machine it wakes. Each clock edge during a search performs exactly one action: wake, advance, stall or release.
- R2: A machine that holds the token selects, among its neighbours that are currently idle, the one with the lowest index above the neighbour it last tried. A freshly woken machine considers all of its neighbours. It wakes the selected neighbour and passes the token to it in the same edge.
- R3: A machine that has no idle neighbour left enters a stalled state. On the next edge it returns to idle and hands the token back to its recorded parent. The parent then resumes its own scan from R2.
- R4: When vertex 0 releases, the search ends with `done`=1 and `found`=0.
- R5: When a freshly woken machine finds every vertex busy and has an edge to vertex 0, the search ends with `done`=1 and `found`=1. This test applies only when N is at least 3.
- R6: `start` is honoured only when no search is running. It captures `adjIn`, clears all machines and wakes vertex 0. A `start` during a search changes neither the graph, nor the counter, nor the outcome.
- R7: Bit `i*N+j` of `adjIn` marks an edge between vertices i and j. An edge exists if either of its two bits is set. Diagonal bits (self-loops) are ignored.
- R8: `done` is cleared by an accepted `start`. After a verdict, `done` remains 1 and `found` and `cycleCount` remain unchanged until the next accepted `start`.
- R9: `cycleCount` equals the number of clock edges after the start edge, up to and including the edge that sets `done`. It saturates at its maximum value.
- R10: With N below 3, every search ends with `found`=0.
- R11: A synchronous active-high `rst` returns all machines to idle and clears `done`, `found` and `cycleCount`. It also aborts a search in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search |
| adjIn | input | N*N | Adjacency matrix, bit i*N+j for the pair (i, j) |
| done | output | 1 | The search has finished; held until the next start |
| found | output | 1 | Verdict: 1 if a Hamiltonian cycle exists |
| cycleCount | output | CW | Clock edges taken by the last or current search |

## Verification
The hardest case to reach from the ports is a parent that resumes its scan after a child has backtracked. To exercise it, the parent's first choice must dead-end, and a later neighbour in ascending order must then lead to a full tour. The graphs in the bench are built so that this happens, and so that the machines the failed branch released become available again. Because the exact cycle count is checked, every stall, release and resume appears at the ports. Hand-traced edge counts for each graph therefore pin down the ordering of neighbours and the one-action-per-edge timing.

// File: rtl/hc_pkg.sv
package hc_pkg;

  // command from the search control to one vertex machine
  typedef enum logic [2:0] {
    V_NONE,
    V_CLEAR,
    V_WAKE,
    V_ADVANCE,
    V_STUCK,
    V_RELEASE
  } vcmd_t;

  // per-vertex state: idle, just woken, parked on a neighbour, stalled
  typedef enum logic [1:0] {
    VS_IDLE,
    VS_AWAKE,
    VS_NBR,
    VS_STUCK
  } vstate_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAdj;
    logic countClr;
    logic countEn;
    logic setFound;
    logic setMiss;
  } dpStrobe_t;

endpackage

// File: rtl/hc_vertex_fsm.sv
module hc_vertex_fsm
  import hc_pkg::*;
#(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  vcmd_t         cmd,
  input  logic [IW-1:0] parentIn,
  input  logic [N-1:0]  adjRow,
  input  logic [N-1:0]  idleVec,
  output logic          isIdle,
  output logic          isAwake,
  output logic          isStuck,
  output logic          hasNext,
  output logic [IW-1:0] nextIdx,
  output logic [IW-1:0] parentIdx
);

  vstate_t       state;
  logic [IW-1:0] ptr;
  logic [N-1:0]  cand;

  // candidates: adjacent, idle, and beyond the last tried neighbour
  always_comb begin
    for (int j = 0; j < N; j++) begin
      cand[j] = adjRow[j] && idleVec[j] &&
                ((state == VS_AWAKE) || (IW'(j) > ptr));
    end
  end

  // lowest-index candidate wins
  always_comb begin
    nextIdx = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (cand[j]) nextIdx = IW'(j);
    end
  end

  assign hasNext = |cand;
  assign isIdle  = (state == VS_IDLE);
  assign isAwake = (state == VS_AWAKE);
  assign isStuck = (state == VS_STUCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= VS_IDLE;
      ptr       <= '0;
      parentIdx <= '0;
    end else begin
      case (cmd)
        V_CLEAR:   state <= VS_IDLE;
        V_WAKE: begin
          state     <= VS_AWAKE;
          parentIdx <= parentIn;
        end
        V_ADVANCE: begin
          state <= VS_NBR;
          ptr   <= nextIdx;
        end
        V_STUCK:   state <= VS_STUCK;
        V_RELEASE: state <= VS_IDLE;
        default:   ;
      endcase
    end
  end

  // R3: control releases only a machine that has stalled
  a_r3_release_after_stall: assert property (@(posedge clk) disable iff (rst)
    cmd == V_RELEASE |-> state == VS_STUCK);

  // R2: an advance is only ordered when an idle neighbour remains
  a_r2_advance_has_target: assert property (@(posedge clk) disable iff (rst)
    cmd == V_ADVANCE |-> hasNext);

  // R3: a stalled machine waits in that state until the release arrives
  a_r3_stall_held: assert property (@(posedge clk) disable iff (rst)
    (state == VS_STUCK) && (cmd == V_NONE) |=> state == VS_STUCK);

endmodule

// File: rtl/hc_search_ctrl.sv
module hc_search_ctrl
  import hc_pkg::*;
#(
  parameter int N           = 5,
  parameter int IW          = 3,
  parameter bit CHECK_FOUND = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [N*N-1:0] adjFlat,
  output dpStrobe_t    strobe
);

  logic          run, runNext;
  logic [IW-1:0] owner, ownerNext, parentBus;
  vcmd_t         cmdArr [N];
  logic [N-1:0]  idleVec, awakeVec, stuckVec, hasNextVec;
  logic [IW-1:0] nextArr [N];
  logic [IW-1:0] parentArr [N];
  logic          allActive;

  assign allActive = ~|idleVec;

  for (genvar v = 0; v < N; v++) begin : g_vtx
    hc_vertex_fsm #(.N(N), .IW(IW)) u_vtx (
      .clk       (clk),
      .rst       (rst),
      .cmd       (cmdArr[v]),
      .parentIn  (parentBus),
      .adjRow    (adjFlat[v*N +: N]),
      .idleVec   (idleVec),
      .isIdle    (idleVec[v]),
      .isAwake   (awakeVec[v]),
      .isStuck   (stuckVec[v]),
      .hasNext   (hasNextVec[v]),
      .nextIdx   (nextArr[v]),
      .parentIdx (parentArr[v])
    );
  end

  always_comb begin
    for (int v = 0; v < N; v++) cmdArr[v] = V_NONE;
    strobe    = '0;
    runNext   = run;
    ownerNext = owner;
    parentBus = owner;
    if (!run) begin
      if (start) begin
        for (int v = 0; v < N; v++) cmdArr[v] = V_CLEAR;
        cmdArr[0]       = V_WAKE;
        parentBus       = '0;
        runNext         = 1'b1;
        ownerNext       = '0;
        strobe.latchAdj = 1'b1;
        strobe.countClr = 1'b1;
      end
    end else begin
      strobe.countEn = 1'b1;
      if (CHECK_FOUND && awakeVec[owner] && allActive &&
          adjFlat[int'(owner) * N]) begin
        strobe.setFound = 1'b1;
        runNext         = 1'b0;
      end else if (stuckVec[owner]) begin
        cmdArr[owner] = V_RELEASE;
        if (owner == '0) begin
          strobe.setMiss = 1'b1;
          runNext        = 1'b0;
        end else begin
          ownerNext = parentArr[owner];
        end
      end else if (hasNextVec[owner]) begin
        cmdArr[owner]          = V_ADVANCE;
        cmdArr[nextArr[owner]] = V_WAKE;
        ownerNext              = nextArr[owner];
      end else begin
        cmdArr[owner] = V_STUCK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      owner <= '0;
    end else begin
      run   <= runNext;
      owner <= ownerNext;
    end
  end

  // R1: only the token holder can be freshly woken or stalled
  a_r1_one_fresh: assert property (@(posedge clk) disable iff (rst)
    $countones(awakeVec) <= 1);
  a_r1_one_stall: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stuckVec));

  // R4: the root stays busy for the whole search
  a_r4_root_busy: assert property (@(posedge clk) disable iff (rst)
    run |-> !idleVec[0]);

  // R6: a start during a search does not restart it
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    run && start |-> !strobe.countClr && !strobe.latchAdj);

endmodule

// File: rtl/hc_datapath.sv
module hc_datapath
  import hc_pkg::*;
#(
  parameter int N  = 5,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  dpStrobe_t      strobe,
  input  logic [N*N-1:0] adjIn,
  output logic [N*N-1:0] adjFlat,
  output logic           done,
  output logic           found,
  output logic [CW-1:0]  cycleCount
);

  logic [N*N-1:0] adjSym;

  // symmetric closure with diagonal removed
  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        adjSym[i*N+j] = (i != j) && (adjIn[i*N+j] || adjIn[j*N+i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adjFlat    <= '0;
      done       <= 1'b0;
      found      <= 1'b0;
      cycleCount <= '0;
    end else begin
      if (strobe.latchAdj) adjFlat <= adjSym;
      if (strobe.countClr) begin
        cycleCount <= '0;
        done       <= 1'b0;
        found      <= 1'b0;
      end else begin
        if (strobe.countEn && !(&cycleCount)) cycleCount <= cycleCount + 1'b1;
        if (strobe.setFound) begin
          done  <= 1'b1;
          found <= 1'b1;
        end else if (strobe.setMiss) begin
          done  <= 1'b1;
          found <= 1'b0;
        end
      end
    end
  end

  // R8: verdict and count hold until the next accepted start
  a_r8_verdict_hold: assert property (@(posedge clk) disable iff (rst)
    done && !strobe.countClr |=> done && $stable(found) && $stable(cycleCount));

  // R5: a positive verdict is only visible together with done
  a_r5_found_with_done: assert property (@(posedge clk) disable iff (rst)
    found |-> done);

  // R11: reset clears the outputs
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> !done && !found && cycleCount == '0);

endmodule

// File: rtl/hc_solver.sv
module hc_solver
  import hc_pkg::*;
#(
  parameter int N  = 5,
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N*N-1:0] adjIn,
  output logic           done,
  output logic           found,
  output logic [CW-1:0]  cycleCount
);

  localparam int IW          = (N > 1) ? $clog2(N) : 1;
  localparam bit CHECK_FOUND = (N >= 3);  // R10: tiny graphs never report a hit

  dpStrobe_t      strobe;
  logic [N*N-1:0] adjFlat;

  hc_search_ctrl #(.N(N), .IW(IW), .CHECK_FOUND(CHECK_FOUND)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .adjFlat (adjFlat),
    .strobe  (strobe)
  );

  hc_datapath #(.N(N), .CW(CW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .adjIn      (adjIn),
    .adjFlat    (adjFlat),
    .done       (done),
    .found      (found),
    .cycleCount (cycleCount)
  );

endmodule

// File: tb/tb_hc_solver.sv
module tb_hc_solver;

  localparam int N  = 4;
  localparam int CW = 16;
  localparam int NT = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          start, startPair;
  logic [N*N-1:0] adjIn;
  logic [3:0]    adjPair;
  logic          done, found, donePair, foundPair;
  logic [CW-1:0] cycleCount, countPair;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  hc_solver #(.N(N), .CW(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .adjIn(adjIn),
    .done(done), .found(found), .cycleCount(cycleCount)
  );

  hc_solver #(.N(2), .CW(CW)) dutPair (
    .clk(clk), .rst(rst), .start(startPair), .adjIn(adjPair),
    .done(donePair), .found(foundPair), .cycleCount(countPair)
  );

  // graph, expected verdict, expected edge count (hand traced)
  localparam logic [15:0] ADJ_T [NT] = '{
    16'h5A5A,  // ring 0-1-2-3-0
    16'h4A52,  // path 0-1-2-3
    16'h0000,  // no edges
    16'h6BD6,  // hit only after a resumed scan
    16'h7BDE,  // complete graph
    16'h0356,  // triangle plus isolated vertex
    16'hDE7B,  // ring with self-loops
    16'h084A   // ring given by upper bits only
  };
  localparam bit FND_T [NT] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int CNT_T [NT] = '{4, 11, 2, 10, 4, 14, 4, 4};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(done, "R9 search terminates", int'(done), 1);
  endtask

  task automatic runCase(input logic [15:0] a, input bit expF, input int expC,
                         input string req);
    @(negedge clk);
    adjIn = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done, "R8 done cleared by start", int'(done), 0);
    waitDone();
    check(found == expF, {req, " verdict"}, int'(found), int'(expF));
    check(cycleCount == CW'(expC), {"R9 ", req, " cycle count"}, int'(cycleCount), expC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; startPair = 1'b0; adjIn = '0; adjPair = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(!done && !found, "R11 reset verdict", int'({done, found}), 0);
    check(cycleCount == '0, "R11 reset count", int'(cycleCount), 0);

    // R2 R3 R4 R5 R7: table of graphs
    for (int t = 0; t < NT; t++) begin
      runCase(ADJ_T[t], FND_T[t], CNT_T[t], FND_T[t] ? "R5 R2 R7" : "R4 R3 R7");
    end

    // R8: verdict held long after the finish (last case: hit, count 4)
    repeat (20) @(negedge clk);
    check(done && found, "R8 verdict held", int'({done, found}), 3);
    check(cycleCount == CW'(4), "R8 count held", int'(cycleCount), 4);

    // R6: start during a search is ignored (path graph then complete graph)
    @(negedge clk);
    adjIn = 16'h4A52; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    adjIn = 16'h7BDE; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    check(!found, "R6 late start ignored verdict", int'(found), 0);
    check(cycleCount == CW'(11), "R6 late start ignored count", int'(cycleCount), 11);

    // R11: reset aborts a running search
    @(negedge clk);
    adjIn = 16'h4A52; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!done && !found, "R11 abort verdict", int'({done, found}), 0);
    check(cycleCount == '0, "R11 abort count", int'(cycleCount), 0);
    repeat (4) @(negedge clk);
    check(!done, "R11 no activity after abort", int'(done), 0);
    runCase(16'h5A5A, 1'b1, 4, "R11 R5 after abort");

    // R10: two vertices joined by an edge never report a hit
    @(negedge clk);
    adjPair = 4'b0110; startPair = 1'b1;
    @(negedge clk);
    startPair = 1'b0;
    repeat (10) @(negedge clk);
    check(donePair && !foundPair, "R10 pair verdict", int'({donePair, foundPair}), 2);
    check(countPair == CW'(5), "R10 R1 pair count", int'(countPair), 5);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule